// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a 32-bit physical address by reading a two-level table held in ordinary memory. The linear address is cut into three fields: the top ten bits select a directory slot, the next ten select a slot in the second-level table that the directory slot points to, and the low twelve bits pass through as the offset inside a 4 KiB frame. Along the way the walker checks that each entry is marked present, applies user/supervisor and write permission rules at both levels, and writes back usage bits (accessed, and dirty on writes) with single-word writes when they are not yet set.

A requester hands over one translation at a time on a valid/ready handshake, carrying the linear address, a write flag and a user flag. The directory base register value and the paging-enable bit are sampled when a request is taken. The walker owns a word-wide memory port with a request/acknowledge handshake of any latency. When the walk ends it pulses a one-cycle result carrying either the physical address or a fault flag with a two-bit cause. When paging is off the address passes straight through and memory is not touched.

Top module: `lin2phys_walker`

## Requirements
- R1: When `paging_en` is 0 at the accepting edge, the result reports `rsp_phys` equal to the linear address with `rsp_fault`=0 one cycle later, and no memory access takes place.
- R2: The directory entry is read from word address {`dir_base`[31:12], lin[31:22], 2'b00}; the second-level entry is read from {directory entry[31:12], lin[21:12], 2'b00}.
- R3: A walk without fault returns `rsp_phys` = {second-level entry[31:12], lin[11:0]}, `rsp_fault`=0 and `rsp_cause`=0.
- R4: A directory entry with bit 0 (present) at 0 ends the walk with `rsp_fault`=1 and `rsp_cause`=1, and no further memory access is issued for that request.
- R5: A second-level entry with bit 0 at 0 ends the walk with `rsp_fault`=1 and `rsp_cause`=2, and that entry is not written.
- R6: When a usable directory entry has bit 5 (accessed) at 0, it is written back once as the read value with only bit 5 set; bit 6 of a directory entry is never changed, and no write happens when bit 5 was already 1.
- R7: On a successful walk, the second-level entry is written back as its read value with bit 5 set and, for a write request, bit 6 (dirty) set; the write is skipped when these bits were already 1, and no bit is ever cleared.
- R8: A user request (`req_user`=1) meeting an entry with bit 2 (user) at 0, or a user write meeting an entry with bit 1 (writable) at 0, at either level, ends with `rsp_fault`=1 and `rsp_cause`=3 without writing that entry; supervisor requests ignore bits 1 and 2.
- R9: `req_ready` is high only while no request is in progress, `rsp_valid` is a single-cycle pulse, and the walker is ready again in the cycle after it.
- R10: While `mem_req` is high and `mem_ack` has not arrived, `mem_addr`, `mem_we` and `mem_wdata` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| paging_en | input | 1 | Translation enable, sampled on request acceptance |
| dir_base | input | 32 | Directory base register; bits 31:12 used |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to accept |
| req_lin | input | 32 | Linear address |
| req_write | input | 1 | Request is a write access |
| req_user | input | 1 | Request comes from user mode |
| rsp_valid | output | 1 | One-cycle result pulse |
| rsp_phys | output | 32 | Physical address (valid when no fault) |
| rsp_fault | output | 1 | Translation failed |
| rsp_cause | output | 2 | 0 none, 1 directory not present, 2 table not present, 3 protection |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Byte address of the entry word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Memory access complete |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |

## Verification
The bench goes after entries whose usage bits are already set, where a design that always writes back would issue extra memory writes the reference model does not expect, and write requests reaching a directory entry, where a design that sets dirty at the wrong level would put bit 6 into the directory write-back. Missing entries at each level check that the walk stops with the right cause instead of reading a stale frame. User/supervisor mixes with read-only and supervisor-only entries at both levels expose a swapped or one-level-only permission check as a wrong cause or a wrong address. A memory responder with varying latency, together with a change of directory base, catches walkers that drop the address before acknowledge or ignore the base.

// File: rtl/walk_pkg.sv
package walk_pkg;
    localparam int VA_W    = 32;
    localparam int OFF_W   = 12;
    localparam int IDX_W   = 10;
    localparam int FRAME_W = VA_W - OFF_W;
    localparam int DIR_LO  = OFF_W + IDX_W;
    localparam int WORD_LG = VA_W - FRAME_W - IDX_W;

    localparam int BIT_PRES = 0;
    localparam int BIT_WR   = 1;
    localparam int BIT_USR  = 2;
    localparam int BIT_ACC  = 5;
    localparam int BIT_DTY  = 6;

    typedef enum logic [2:0] {
        ST_IDLE, ST_DIR_RD, ST_DIR_WR, ST_TBL_RD, ST_TBL_WR, ST_DONE
    } walk_st_e;

    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'd0,
        CAUSE_DIR_NP = 2'd1,
        CAUSE_TBL_NP = 2'd2,
        CAUSE_PROT   = 2'd3
    } cause_e;

    typedef struct packed {
        walk_st_e           state;
        logic [VA_W-1:0]    lin;
        logic               wr;
        logic               usr;
        logic [FRAME_W-1:0] base;
        logic [FRAME_W-1:0] frame;
        logic [VA_W-1:0]    wdata;
        logic [VA_W-1:0]    phys;
        logic               fault;
        cause_e             cause;
    } walk_reg_t;
endpackage

// File: rtl/walk_entry_eval.sv
module walk_entry_eval
    import walk_pkg::*;
(
    input  logic [VA_W-1:0] entry,
    input  logic            leaf,
    input  logic            acc_write,
    input  logic            acc_user,
    output logic            present,
    output logic            allowed,
    output logic [VA_W-1:0] upd_word,
    output logic            upd_needed
);
    logic [VA_W-1:0] set_mask;

    always_comb begin
        set_mask = '0;
        set_mask[BIT_ACC] = 1'b1;
        set_mask[BIT_DTY] = leaf && acc_write;
        present    = entry[BIT_PRES];
        allowed    = !acc_user || (entry[BIT_USR] && (!acc_write || entry[BIT_WR]));
        upd_word   = entry | set_mask;
        upd_needed = (upd_word != entry);
    end
endmodule

// File: rtl/walk_addr_calc.sv
module walk_addr_calc
    import walk_pkg::*;
(
    input  logic [FRAME_W-1:0] frame,
    input  logic [IDX_W-1:0]   idx,
    output logic [VA_W-1:0]    addr
);
    always_comb addr = {frame, idx, {WORD_LG{1'b0}}};
endmodule

// File: rtl/lin2phys_walker.sv
module lin2phys_walker
    import walk_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            paging_en,
    input  logic [VA_W-1:0] dir_base,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [VA_W-1:0] req_lin,
    input  logic            req_write,
    input  logic            req_user,
    output logic            rsp_valid,
    output logic [VA_W-1:0] rsp_phys,
    output logic            rsp_fault,
    output logic [1:0]      rsp_cause,
    output logic            mem_req,
    output logic            mem_we,
    output logic [VA_W-1:0] mem_addr,
    output logic [VA_W-1:0] mem_wdata,
    input  logic            mem_ack,
    input  logic [VA_W-1:0] mem_rdata
);
    walk_reg_t q, d;

    logic               ent_present, ent_allowed, ent_upd_needed;
    logic [VA_W-1:0]    ent_upd_word;
    logic               in_tbl;
    logic [FRAME_W-1:0] sel_frame;
    logic [IDX_W-1:0]   sel_idx;
    logic               unused_base_lo;

    assign unused_base_lo = ^dir_base[OFF_W-1:0];

    walk_entry_eval u_eval (
        .entry      (mem_rdata),
        .leaf       (in_tbl),
        .acc_write  (q.wr),
        .acc_user   (q.usr),
        .present    (ent_present),
        .allowed    (ent_allowed),
        .upd_word   (ent_upd_word),
        .upd_needed (ent_upd_needed)
    );

    always_comb begin
        in_tbl    = (q.state == ST_TBL_RD) || (q.state == ST_TBL_WR);
        sel_frame = in_tbl ? q.frame : q.base;
        sel_idx   = in_tbl ? q.lin[DIR_LO-1:OFF_W] : q.lin[VA_W-1:DIR_LO];
    end

    walk_addr_calc u_addr (
        .frame (sel_frame),
        .idx   (sel_idx),
        .addr  (mem_addr)
    );

    always_comb begin
        d = q;
        unique case (q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    d.lin   = req_lin;
                    d.wr    = req_write;
                    d.usr   = req_user;
                    d.fault = 1'b0;
                    d.cause = CAUSE_NONE;
                    d.base  = dir_base[VA_W-1:OFF_W];
                    if (paging_en) begin
                        d.phys  = '0;
                        d.state = ST_DIR_RD;
                    end else begin
                        d.phys  = req_lin;
                        d.state = ST_DONE;
                    end
                end
            end
            ST_DIR_RD: begin
                if (mem_ack) begin
                    if (!ent_present) begin
                        d.fault = 1'b1;
                        d.cause = CAUSE_DIR_NP;
                        d.state = ST_DONE;
                    end else if (!ent_allowed) begin
                        d.fault = 1'b1;
                        d.cause = CAUSE_PROT;
                        d.state = ST_DONE;
                    end else begin
                        d.frame = mem_rdata[VA_W-1:OFF_W];
                        d.wdata = ent_upd_word;
                        d.state = ent_upd_needed ? ST_DIR_WR : ST_TBL_RD;
                    end
                end
            end
            ST_DIR_WR: begin
                if (mem_ack) d.state = ST_TBL_RD;
            end
            ST_TBL_RD: begin
                if (mem_ack) begin
                    if (!ent_present) begin
                        d.fault = 1'b1;
                        d.cause = CAUSE_TBL_NP;
                        d.state = ST_DONE;
                    end else if (!ent_allowed) begin
                        d.fault = 1'b1;
                        d.cause = CAUSE_PROT;
                        d.state = ST_DONE;
                    end else begin
                        d.phys  = {mem_rdata[VA_W-1:OFF_W], q.lin[OFF_W-1:0]};
                        d.wdata = ent_upd_word;
                        d.state = ent_upd_needed ? ST_TBL_WR : ST_DONE;
                    end
                end
            end
            ST_TBL_WR: begin
                if (mem_ack) d.state = ST_DONE;
            end
            ST_DONE:  d.state = ST_IDLE;
            default:  d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
            q.cause <= CAUSE_NONE;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        req_ready = (q.state == ST_IDLE);
        rsp_valid = (q.state == ST_DONE);
        rsp_phys  = q.phys;
        rsp_fault = q.fault;
        rsp_cause = q.cause;
        mem_req   = (q.state == ST_DIR_RD) || (q.state == ST_DIR_WR) ||
                    (q.state == ST_TBL_RD) || (q.state == ST_TBL_WR);
        mem_we    = (q.state == ST_DIR_WR) || (q.state == ST_TBL_WR);
        mem_wdata = q.wdata;
    end
endmodule

// File: rtl/walk_checker.sv
module walk_checker
    import walk_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            paging_en,
    input logic            req_valid,
    input logic            req_ready,
    input logic            rsp_valid,
    input logic            rsp_fault,
    input logic [1:0]      rsp_cause,
    input logic            mem_req,
    input logic            mem_we,
    input logic [VA_W-1:0] mem_addr,
    input logic [VA_W-1:0] mem_wdata,
    input logic            mem_ack
);
    p_bypass_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !paging_en) |=> (rsp_valid && !rsp_fault));

    p_fault_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_cause != 2'd0));

    p_clean_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (rsp_cause == 2'd0));

    p_acc_written_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> mem_wdata[BIT_ACC]);

    p_rsp_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req);

    p_mem_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=>
            (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
endmodule

bind lin2phys_walker walk_checker u_walk_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .paging_en (paging_en),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_fault (rsp_fault),
    .rsp_cause (rsp_cause),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack)
);

// File: tb/lin2phys_walker_tb_top.sv
module lin2phys_walker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        paging_en = 1'b0;
    logic [31:0] dir_base = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_lin = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic        rsp_valid;
    logic [31:0] rsp_phys;
    logic        rsp_fault;
    logic [1:0]  rsp_cause;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    lin2phys_walker dut_i (.*);

    logic [31:0] mem [int];
    bit          exp_we [$];
    logic [31:0] exp_addr [$];
    logic [31:0] exp_wd [$];
    string       exp_tag [$];

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(int'(a >> 2)) ? mem[int'(a >> 2)] : 32'h0;
    endfunction

    task automatic push_op(input bit we, input logic [31:0] a,
                           input logic [31:0] wd, input string tag);
        exp_we.push_back(we);
        exp_addr.push_back(a);
        exp_wd.push_back(wd);
        exp_tag.push_back(tag);
    endtask

    // Reference model: expected memory traffic and result of one walk.
    task automatic model(input logic [31:0] lin, input bit wr, input bit usr,
                         input bit pg, input logic [31:0] base,
                         output logic [31:0] phys, output bit fault,
                         output logic [1:0] cause, output string tag);
        logic [31:0] da, de, ta, te, nv;
        phys = '0; fault = 0; cause = 2'd0; tag = "R3";
        if (!pg) begin phys = lin; tag = "R1"; return; end
        da = {base[31:12], lin[31:22], 2'b00};
        de = rd(da);
        push_op(0, da, 0, "R2");
        if (!de[0]) begin fault = 1; cause = 2'd1; tag = "R4"; return; end
        if (usr && (!de[2] || (wr && !de[1]))) begin fault = 1; cause = 2'd3; tag = "R8"; return; end
        if (!de[5]) push_op(1, da, de + 32'h20, "R6");
        ta = {de[31:12], lin[21:12], 2'b00};
        te = rd(ta);
        push_op(0, ta, 0, "R2");
        if (!te[0]) begin fault = 1; cause = 2'd2; tag = "R5"; return; end
        if (usr && (!te[2] || (wr && !te[1]))) begin fault = 1; cause = 2'd3; tag = "R8"; return; end
        nv = te;
        if (!nv[5]) nv = nv + 32'h20;
        if (wr && !nv[6]) nv = nv + 32'h40;
        if (nv != te) push_op(1, ta, nv, "R7");
        phys = {te[31:12], lin[11:0]};
    endtask

    // Memory responder with varying latency; checks every access against the model.
    int          lat_seed = 0;
    bit          pend = 0;
    int          delay = 0;
    logic [31:0] held_addr, held_wd;
    bit          held_we;

    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (rst_n && mem_req) begin
            if (!pend) begin
                pend = 1;
                held_addr = mem_addr; held_we = mem_we; held_wd = mem_wdata;
                lat_seed++;
                delay = (lat_seed * 7) % 4;
            end else begin
                chk(mem_addr == held_addr && mem_we == held_we && mem_wdata == held_wd,
                    "R10", "held address", mem_addr, held_addr);
            end
            if (delay == 0) begin
                pend = 0;
                if (exp_we.size() == 0) begin
                    chk(0, "R1 R4 R5", "unexpected memory access", mem_addr, 32'h0);
                end else begin
                    automatic bit          ew = exp_we.pop_front();
                    automatic logic [31:0] ea = exp_addr.pop_front();
                    automatic logic [31:0] ed = exp_wd.pop_front();
                    automatic string       et = exp_tag.pop_front();
                    chk(mem_we == ew, et, "access kind", {31'b0, mem_we}, {31'b0, ew});
                    chk(mem_addr == ea, et, "access address", mem_addr, ea);
                    if (ew) chk(mem_wdata == ed, et, "written entry", mem_wdata, ed);
                end
                mem_rdata <= rd(mem_addr);
                if (mem_we) mem[int'(mem_addr >> 2)] = mem_wdata;
                mem_ack <= 1'b1;
            end else begin
                delay--;
            end
        end
    end

    task automatic walk(input logic [31:0] lin, input bit wr, input bit usr, input bit pg);
        logic [31:0] ephys; bit efault; logic [1:0] ecause; string tag;
        int wait_cnt;
        @(negedge clk);
        model(lin, wr, usr, pg, dir_base, ephys, efault, ecause, tag);
        chk(req_ready == 1'b1, "R9", "ready before request", {31'b0, req_ready}, 32'h1);
        paging_en = pg; req_lin = lin; req_write = wr; req_user = usr; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        wait_cnt = 0;
        while (!rsp_valid && wait_cnt < 200) begin
            chk(req_ready == 1'b0, "R9", "ready while busy", {31'b0, req_ready}, 32'h0);
            @(negedge clk);
            wait_cnt++;
        end
        chk(rsp_valid == 1'b1, tag, "result arrived", {31'b0, rsp_valid}, 32'h1);
        chk(rsp_fault == efault, tag, "fault flag", {31'b0, rsp_fault}, {31'b0, efault});
        chk(rsp_cause == ecause, tag, "cause", {30'b0, rsp_cause}, {30'b0, ecause});
        if (!efault) chk(rsp_phys == ephys, tag, "physical address", rsp_phys, ephys);
        chk(exp_we.size() == 0, tag, "pending expected accesses", exp_we.size(), 32'h0);
        exp_we.delete(); exp_addr.delete(); exp_wd.delete(); exp_tag.delete();
        @(negedge clk);
        chk(rsp_valid == 1'b0 && req_ready == 1'b1, "R9", "single result pulse",
            {30'b0, rsp_valid, req_ready}, 32'h1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // Directory at 0x10000: slot 1 -> table 0x20000, slot 5 supervisor-only -> table 0x21000
        mem[32'h10004 >> 2] = 32'h0002_0007;
        mem[32'h10014 >> 2] = 32'h0002_1003;
        mem[32'h1000C >> 2] = 32'h0002_2047;             // dirty pattern in directory entry
        mem[(32'h20000 + 3*4) >> 2] = 32'h0ABC_D007;
        mem[(32'h20000 + 6*4) >> 2] = 32'h0055_5025;     // user, read-only, accessed
        mem[(32'h20000 + 7*4) >> 2] = 32'h0066_6067;     // accessed and dirty already
        mem[32'h21000 >> 2]         = 32'h0077_7001;     // supervisor-only, read-only
        mem[32'h22000 >> 2]         = 32'h0088_8007;
        // Second directory at 0x30000, slot 1 -> table 0x23000
        mem[32'h30004 >> 2] = 32'h0002_3027;
        mem[(32'h23000 + 3*4) >> 2] = 32'h0099_9027;
        dir_base = 32'h0001_0ABC;                        // low bits must be ignored
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(req_ready == 1'b1 && rsp_valid == 1'b0 && mem_req == 1'b0, "R9",
            "state during reset", {29'b0, req_ready, rsp_valid, mem_req}, 32'h4);
        rst_n = 1'b1;

        walk(32'hDEAD_BEEF, 1, 1, 0);                    // R1 bypass
        walk(32'h0040_3123, 0, 0, 1);                    // R2 R3 R6 R7 first use
        walk(32'h0040_3456, 0, 1, 1);                    // usage bits now set: reads only
        walk(32'h0040_3FFF, 1, 1, 1);                    // R7 dirty on write
        walk(32'h0040_4000, 0, 0, 1);                    // R5 table entry missing
        walk(32'h0080_0010, 0, 0, 1);                    // R4 directory entry missing
        walk(32'h0140_0200, 0, 1, 1);                    // R8 user vs supervisor directory
        walk(32'h0140_0200, 1, 0, 1);                    // R8 supervisor write ignores bits
        walk(32'h0040_6ABC, 1, 1, 1);                    // R8 user write to read-only table
        walk(32'h0040_6ABC, 0, 1, 1);                    // user read of same page allowed
        walk(32'h0040_7001, 1, 0, 1);                    // R7 bits already set: no write
        walk(32'h00C0_0777, 1, 0, 1);                    // R6 directory keeps bit 6
        walk(32'h1234_5678, 0, 0, 0);                    // R1 bypass again
        dir_base = 32'h0003_0000;
        walk(32'h0040_3010, 1, 1, 1);                    // R2 new base
        for (int i = 0; i < 4; i++) walk(32'h0040_3000 + i * 32'h11, i[0], i[1], 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule